// File: doc/BRIEF.md
# Banked Memory Region Mapper

This block places a 64 KB CPU address space onto two 512 KB physical devices: a static RAM and a flash part. The CPU space is cut into four 16 KB windows chosen by the top two address bits. Each window can point at any 16 KB page of either device, and each window has its own write lock. The CPU changes the mapping at run time through four I/O-mapped control registers. It can read those registers back.

On the memory side the block drives a 19-bit physical address built from the window's page number and the low 14 CPU address bits. It also drives one chip select per device and a write enable that is held off for locked windows. Address translation, chip selects and the write enable are combinational on the current CPU cycle. A control register write takes effect at the following clock edge. After reset, window 0 shows flash page 0 and is locked, so the boot code runs. Windows 1 to 3 show SRAM pages 1 to 3 and are writable.

Top module: `bank_mapper`

## Requirements
- R1: While a memory cycle is running, `phys_addr_o` equals {page, `addr_i[13:0]`}. The page is the 5-bit page field of the window selected by `addr_i[15:14]`.
- R2: During a memory cycle (`mreq_i`=1, `iorq_i`=0) exactly one chip select is high. It is `sram_cs_o` when the window's device bit is 0 and `flash_cs_o` when it is 1.
- R3: When `mreq_i` is 0 or `iorq_i` is 1, both chip selects and `mem_we_o` are low.
- R4: `mem_we_o` is high only when a memory write cycle (`mreq_i`, `wr_i`, no `iorq_i`) addresses a window whose lock bit is 0.
- R5: Each window has a control register at I/O port `IO_BASE`+n (n = window 0..3, low address byte, default base 0x40). Its fields are bit 7 = write lock, bit 6 = device (0 SRAM, 1 flash) and bits 4:0 = page. A cycle with `iorq_i` and `wr_i` loads `data_i` into the register at the clock edge, and the new mapping applies from the next cycle on.
- R6: A cycle with `iorq_i` and `rd_i` on a register port returns the register on `data_o`, with bit 5 reading 0. At all other times `data_o` is 0.
- R7: After reset, the registers read 0xC0, 0x01, 0x02 and 0x03 for windows 0 to 3.
- R8: I/O writes to ports outside `IO_BASE`..`IO_BASE`+3, I/O reads, and memory cycles leave all control registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| data_i | input | 8 | CPU write data for control registers |
| data_o | output | 8 | Control register read data, 0 when not selected |
| mreq_i | input | 1 | Memory request |
| iorq_i | input | 1 | I/O request |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| phys_addr_o | output | 19 | Physical device address |
| sram_cs_o | output | 1 | SRAM chip select |
| flash_cs_o | output | 1 | Flash chip select |
| mem_we_o | output | 1 | Gated device write enable |

## Verification
A register update and a memory access decode can fall in the same cycle. The bench provokes this by raising `mreq_i`, `iorq_i` and `wr_i` together while writing a new mapping for window 1. In that cycle it checks that no chip select and no write enable escape. In the next pure memory cycle it checks that the new page, device and lock are in force. Around this, the bench sweeps every window, device and page with both lock settings, and compares address, selects, write enable and readback against values it computes itself.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int REGION_N = 4;
  localparam int PAGE_W   = 5;
  localparam int OFS_W    = 14;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int PHYS_W   = PAGE_W + OFS_W;
  localparam int IDX_W    = $clog2(REGION_N);
  localparam int PAD_W    = DATA_W - 2 - PAGE_W;

  typedef struct packed {
    logic              lock;
    logic              dev;   // 0 SRAM, 1 flash
    logic [PAGE_W-1:0] page;
  } region_cfg_t;
endpackage

// File: rtl/bank_regs.sv
module bank_regs
  import bank_mapper_pkg::*;
#(
  parameter logic [7:0] IO_BASE = 8'h40
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [7:0]                 port_i,
  input  logic [DATA_W-1:0]          data_i,
  input  logic                       iorq_i,
  input  logic                       rd_i,
  input  logic                       wr_i,
  output logic [DATA_W-1:0]          data_o,
  output region_cfg_t [REGION_N-1:0] cfg_o
);
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             io_wr;

  assign hit   = (port_i[7:IDX_W] == IO_BASE[7:IDX_W]);
  assign idx   = port_i[IDX_W-1:0];
  assign io_wr = iorq_i && wr_i && hit;

  region_cfg_t [REGION_N-1:0] cfg_q;

  for (genvar k = 0; k < REGION_N; k++) begin : g_reg
    localparam region_cfg_t RST =
      (k == 0) ? region_cfg_t'{lock: 1'b1, dev: 1'b1, page: '0}
               : region_cfg_t'{lock: 1'b0, dev: 1'b0, page: PAGE_W'(k)};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[k] <= RST;
      end else if (io_wr && idx == IDX_W'(k)) begin
        cfg_q[k] <= '{lock: data_i[7], dev: data_i[6], page: data_i[PAGE_W-1:0]};
      end
    end

    a_r5_reg_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (io_wr && idx == IDX_W'(k)) |=>
        (cfg_q[k].lock == $past(data_i[7]) && cfg_q[k].dev == $past(data_i[6])
         && cfg_q[k].page == $past(data_i[PAGE_W-1:0])));
  end

  assign cfg_o = cfg_q;

  always_comb begin
    data_o = '0;
    if (iorq_i && rd_i && hit)
      data_o = {cfg_q[idx].lock, cfg_q[idx].dev, {PAD_W{1'b0}}, cfg_q[idx].page};
  end

  a_r8_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_wr |=> $stable(cfg_q));
  a_r6_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_o[5] == 1'b0);
endmodule

// File: rtl/bank_decode.sv
module bank_decode
  import bank_mapper_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  region_cfg_t [REGION_N-1:0] cfg_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       mreq_i,
  input  logic                       iorq_i,
  input  logic                       wr_i,
  output logic [PHYS_W-1:0]          phys_addr_o,
  output logic                       sram_cs_o,
  output logic                       flash_cs_o,
  output logic                       mem_we_o
);
  logic [IDX_W-1:0] sel;
  region_cfg_t      cur;
  logic             mem_cyc;

  assign sel     = addr_i[ADDR_W-1 -: IDX_W];
  assign cur     = cfg_i[sel];
  assign mem_cyc = mreq_i && !iorq_i;

  assign phys_addr_o = {cur.page, addr_i[OFS_W-1:0]};
  assign sram_cs_o   = mem_cyc && !cur.dev;
  assign flash_cs_o  = mem_cyc &&  cur.dev;
  assign mem_we_o    = mem_cyc && wr_i && !cur.lock;

  a_r3_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreq_i || iorq_i) |-> !(sram_cs_o || flash_cs_o || mem_we_o));
  a_r2_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_i && !iorq_i) |-> $onehot({sram_cs_o, flash_cs_o}));
  a_r4_lock_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[addr_i[ADDR_W-1 -: IDX_W]].lock) |-> !mem_we_o);
  a_r4_we_needs_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (wr_i && (sram_cs_o || flash_cs_o)));
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter logic [7:0] IO_BASE = 8'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  input  logic              mreq_i,
  input  logic              iorq_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [18:0]       phys_addr_o,
  output logic              sram_cs_o,
  output logic              flash_cs_o,
  output logic              mem_we_o
);
  region_cfg_t [REGION_N-1:0] cfg;

  bank_regs #(.IO_BASE(IO_BASE)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .port_i (addr_i[7:0]),
    .data_i (data_i),
    .iorq_i (iorq_i),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .data_o (data_o),
    .cfg_o  (cfg)
  );

  bank_decode u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg),
    .addr_i      (addr_i),
    .mreq_i      (mreq_i),
    .iorq_i      (iorq_i),
    .wr_i        (wr_i),
    .phys_addr_o (phys_addr_o),
    .sram_cs_o   (sram_cs_o),
    .flash_cs_o  (flash_cs_o),
    .mem_we_o    (mem_we_o)
  );

  a_r6_data_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(iorq_i && rd_i) |-> data_o == 8'h00);
endmodule

// File: tb/tb_bank_mapper.sv
module tb_bank_mapper;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        mreq = 0, iorq = 0, rd = 0, wr = 0;
  logic [18:0] paddr;
  logic        scs, fcs, we;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] model [4];

  localparam logic [7:0] BASE = 8'h40;

  always #5 clk = ~clk;

  bank_mapper dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(din), .data_o(dout),
    .mreq_i(mreq), .iorq_i(iorq), .rd_i(rd), .wr_i(wr),
    .phys_addr_o(paddr), .sram_cs_o(scs), .flash_cs_o(fcs), .mem_we_o(we)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    mreq = 0; iorq = 0; rd = 0; wr = 0;
  endtask

  task automatic io_wr(logic [7:0] port, logic [7:0] d);
    @(negedge clk);
    addr = {8'h00, port}; din = d; iorq = 1; wr = 1; rd = 0; mreq = 0;
    @(negedge clk);
    idle();
    if (port[7:2] == BASE[7:2]) model[port[1:0]] = d & 8'hDF;
  endtask

  task automatic io_rd_chk(logic [7:0] port, logic [7:0] exp, string req);
    @(negedge clk);
    addr = {8'h00, port}; iorq = 1; rd = 1; wr = 0; mreq = 0;
    #1 chk(req, dout, exp);
    #1 idle();
  endtask

  // checks translation, selects and write enable for one memory cycle
  task automatic mem_chk(logic [15:0] a, logic w, string req);
    logic [7:0] c;
    @(negedge clk);
    addr = a; mreq = 1; iorq = 0; wr = w; rd = !w;
    c = model[a[15:14]];
    #1;
    chk({req, " phys"}, paddr, {c[4:0], a[13:0]});
    chk({req, " cs"}, {scs, fcs}, c[6] ? 2'b01 : 2'b10);
    chk({req, " we"}, we, w && !c[7]);
    #1 idle();
  endtask

  initial begin
    model[0] = 8'hC0; model[1] = 8'h01; model[2] = 8'h02; model[3] = 8'h03;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R7 reset state
    for (int r = 0; r < 4; r++) io_rd_chk(BASE + 8'(r), model[r], "R7 reset readback");
    mem_chk(16'h0123, 1'b0, "R7 R2 boot flash read");
    mem_chk(16'h0123, 1'b1, "R7 R4 boot lock write");
    mem_chk(16'hC567, 1'b1, "R7 R4 sram writable");

    // R3 idle and R6 data_o zero outside reads
    @(negedge clk);
    addr = 16'h4000; mreq = 0; wr = 1;
    #1 chk("R3 no mreq", {scs, fcs, we}, 3'b000);
    chk("R6 data_o idle", dout, 8'h00);
    idle();

    // sweep window x device x page x lock, bit 5 written as 1
    for (int r = 0; r < 4; r++)
      for (int dv = 0; dv < 2; dv++)
        for (int pg = 0; pg < 32; pg++)
          for (int lk = 0; lk < 2; lk++) begin
            logic [15:0] a;
            io_wr(BASE + 8'(r), {1'(lk), 1'(dv), 1'b1, 5'(pg)});
            io_rd_chk(BASE + 8'(r), {1'(lk), 1'(dv), 1'b0, 5'(pg)}, "R5 R6 readback");
            a = {2'(r), 14'((pg * 517 + dv * 91 + lk * 4099) & 16'h3FFF)};
            mem_chk(a, 1'b0, "R1 R2 read map");
            mem_chk(a, 1'b1, "R4 write gate");
          end

    // R8 ignored ports, memory cycles and I/O reads keep registers
    io_wr(8'h00, 8'h00);
    io_wr(8'h02, 8'h00);
    io_wr(8'h03, 8'h00);
    io_wr(8'h01, 8'h00);
    for (int r = 0; r < 4; r++) io_rd_chk(BASE + 8'(r), model[r], "R8 baseline");
    io_wr(BASE + 8'd4, 8'hFF);
    io_wr(BASE - 8'd1, 8'hFF);
    @(negedge clk);
    addr = {8'h00, BASE}; din = 8'hFF; mreq = 1; wr = 1;
    @(negedge clk); idle();
    @(negedge clk);
    addr = {8'h00, BASE}; din = 8'hFF; iorq = 1; rd = 1;
    @(negedge clk); idle();
    for (int r = 0; r < 4; r++) io_rd_chk(BASE + 8'(r), model[r], "R8 unchanged");
    io_rd_chk(BASE + 8'd4, 8'h00, "R6 unmapped port reads 0");

    // overlap: register write coincides with a memory request
    @(negedge clk);
    addr = {8'h00, BASE + 8'd1}; din = 8'hC9; mreq = 1; iorq = 1; wr = 1;
    #1 chk("R3 overlap no cs/we", {scs, fcs, we}, 3'b000);
    @(negedge clk); idle();
    model[1] = 8'hC9;
    mem_chk(16'h4ABC, 1'b1, "R5 new map next cycle");
    io_wr(BASE + 8'd1, 8'h1E);
    mem_chk(16'h7FFF, 1'b1, "R5 R4 unlocked sram");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule